// File: doc/BRIEF.md
# RSSI Measurement Scheduler

This block decides when received-signal-strength readings are taken. It watches a stream of squared-magnitude power samples, each qualified by a valid strobe. It also watches five restart sources: a gain-locked level, an AGC-enable pin level, an Rx-mode-entry strobe, a gain-change strobe and a configuration-write strobe. A 3-bit mode selects which of these sources can restart the measurement sequence.

After a restart the block waits out a settling delay. It then alternates between measurement windows and wait intervals until a total duration has been spent in those two phases. Each measurement window averages a power-of-two number of valid samples. The mean appears on the result port together with a one-cycle ready pulse. A unit select chooses how delay, wait and duration are counted: in valid Rx samples, or in microseconds taken from a programmable clock prescaler. Converting the result to decibels and correcting it for gain-step errors belong to logic downstream of this block.

Top module: `rssi_sched`

## Requirements
- R1: Each restart mode responds to its own source. Mode 0 responds to a rising edge of `gain_locked`. Mode 1 responds to a rising edge of `agc_en_pin`. Mode 2 responds to `rx_enter`. Mode 3 responds to `gain_chg`. Mode 4 responds to `cfg_wr`. Mode 5 responds to either `gain_chg` or a rising edge of `agc_en_pin`.
- R2: Mode values 6 and 7 behave exactly like mode 2.
- R3: A restart source that the current mode does not select has no effect on the block.
- R4: After every restart, the first `delay_len` time units are only counted. No sample taken during those units enters a result, and no ready pulse occurs during the delay.
- R5: A measurement window sums 2^`win_log2` valid samples. `win_log2` is clamped to LOG_MAX. The window then drives the floor of their mean on `rssi_avg` with `rssi_rdy` high for exactly one cycle. `rssi_avg` changes only together with `rssi_rdy`.
- R6: After a window completes, the block counts `wait_len` time units before the next window opens. Samples that arrive during the wait are discarded.
- R7: Time units spent in measurement and wait phases are counted against `dur_len`. Once the count reaches `dur_len`, a wait phase stops at once. A window that is in progress still completes and reports. No new window starts after that point. The block then stays idle until the next restart.
- R8: With `unit_is_smp` high, one time unit is one valid sample. With it low, one time unit is one microsecond tick, and a tick occurs every `clk_per_us` clock cycles (a value of 0 counts as 1).
- R9: A restart during any phase discards the partial sum and returns the block to the delay phase.
- R10: After reset, `rssi_rdy` and `rssi_avg` are 0. No result is produced until a restart has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_pwr | input | SMP_W | Squared-magnitude power sample |
| smp_vld | input | 1 | Sample valid strobe |
| gain_locked | input | 1 | Gain-lock level (rising edge is the event) |
| agc_en_pin | input | 1 | AGC-enable pin level (rising edge is the event) |
| rx_enter | input | 1 | Strobe on entry to Rx mode |
| gain_chg | input | 1 | Strobe on any gain change |
| cfg_wr | input | 1 | Strobe on a configuration write |
| trig_mode | input | 3 | Restart source select |
| unit_is_smp | input | 1 | 1: time units are valid samples; 0: microseconds |
| clk_per_us | input | DIV_W | Clock cycles per microsecond tick |
| delay_len | input | TIM_W | Settling delay in time units |
| wait_len | input | TIM_W | Gap between windows in time units |
| dur_len | input | DUR_W | Total measure-plus-wait duration in time units |
| win_log2 | input | LW | Log2 of the number of samples per window |
| rssi_avg | output | SMP_W | Mean power of the last completed window |
| rssi_rdy | output | 1 | One-cycle pulse when `rssi_avg` is updated |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 8-bit delay and wait counters, a 16-bit duration counter, an 8-bit prescaler and windows of up to 256 samples. All the tests then run short sequences set from the ports: windows of 1, 2 or 4 samples, delays of a few units, durations that end either inside a wait or exactly at the end of a window, and a 4-cycle microsecond tick. With these settings every restart mode, the boundary between wait and duration, abort during a window and microsecond timing each finish within a few hundred cycles.

// File: rtl/rssi_sched_pkg.sv
package rssi_sched_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DELAY = 2'd1,
      PH_MEAS  = 2'd2,
      PH_WAIT  = 2'd3
   } rssi_phase_e;

   // restart event vector bit positions
   localparam int unsigned EVT_N   = 5;
   localparam int unsigned EV_LOCK = 0;
   localparam int unsigned EV_AGC  = 1;
   localparam int unsigned EV_RXON = 2;
   localparam int unsigned EV_GCHG = 3;
   localparam int unsigned EV_WR   = 4;

   // events that may restart the sequence for a given trigger mode
   function automatic logic [EVT_N-1:0] mode_mask(input logic [2:0] mode);
      logic [EVT_N-1:0] m;
      m = '0;
      case (mode)
         3'd0: m[EV_LOCK] = 1'b1;
         3'd1: m[EV_AGC]  = 1'b1;
         3'd2: m[EV_RXON] = 1'b1;
         3'd3: m[EV_GCHG] = 1'b1;
         3'd4: m[EV_WR]   = 1'b1;
         3'd5: begin
            m[EV_GCHG] = 1'b1;
            m[EV_AGC]  = 1'b1;
         end
         default: m[EV_RXON] = 1'b1;   // 6 and 7 fold onto mode 2
      endcase
      return m;
   endfunction

endpackage

// File: rtl/rssi_trig_sel.sv
module rssi_trig_sel
   import rssi_sched_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gain_locked,
   input  logic       agc_en_pin,
   input  logic       rx_enter,
   input  logic       gain_chg,
   input  logic       cfg_wr,
   input  logic [2:0] trig_mode,
   output logic       restart
);

   localparam int unsigned LVL_N = 2;

   logic [LVL_N-1:0] lvl;
   logic [LVL_N-1:0] rise;
   logic [EVT_N-1:0] evt;

   assign lvl = {agc_en_pin, gain_locked};

   // rising-edge detection on the level-type sources
   for (genvar i = 0; i < LVL_N; i++) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_q;
   end

   always_comb begin
      evt          = '0;
      evt[EV_LOCK] = rise[0];
      evt[EV_AGC]  = rise[1];
      evt[EV_RXON] = rx_enter;
      evt[EV_GCHG] = gain_chg;
      evt[EV_WR]   = cfg_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) restart <= 1'b0;
      else        restart <= |(evt & mode_mask(trig_mode));
   end

endmodule

// File: rtl/rssi_unit_tick.sv
module rssi_unit_tick #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] clk_per_us,
   input  logic             unit_is_smp,
   input  logic             smp_vld,
   output logic             unit_step
);

   logic [DIV_W-1:0] pc_q;
   logic [DIV_W-1:0] lim;
   logic             us_tick;

   // a divide value of zero behaves as one
   assign lim     = (clk_per_us == '0) ? '0 : clk_per_us - 1'b1;
   assign us_tick = (pc_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc_q <= '0;
      else if (us_tick) pc_q <= '0;
      else              pc_q <= pc_q + 1'b1;
   end

   assign unit_step = unit_is_smp ? smp_vld : us_tick;

endmodule

// File: rtl/rssi_phase_fsm.sv
module rssi_phase_fsm
   import rssi_sched_pkg::*;
#(
   parameter int unsigned TIM_W = 8,
   parameter int unsigned DUR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             unit_step,
   input  logic             win_done,
   input  logic [TIM_W-1:0] delay_len,
   input  logic [TIM_W-1:0] wait_len,
   input  logic [DUR_W-1:0] dur_len,
   output rssi_phase_e      phase
);

   rssi_phase_e      ph_q, ph_d;
   logic [TIM_W-1:0] tcnt_q, tcnt_d;
   logic [DUR_W-1:0] dcnt_q, dcnt_d, dcnt_nxt;
   logic             run;
   logic             dur_hit;

   always_comb begin
      run      = (ph_q == PH_MEAS) || (ph_q == PH_WAIT);
      dcnt_nxt = dcnt_q;
      if (run && unit_step && (dcnt_q != '1))
         dcnt_nxt = dcnt_q + 1'b1;
      dur_hit = (dcnt_nxt >= dur_len);

      ph_d   = ph_q;
      tcnt_d = tcnt_q;
      dcnt_d = dcnt_nxt;

      if (restart) begin
         ph_d   = PH_DELAY;
         tcnt_d = '0;
         dcnt_d = '0;
      end else begin
         case (ph_q)
            PH_IDLE: dcnt_d = dcnt_q;
            PH_DELAY: begin
               dcnt_d = '0;
               if (tcnt_q == delay_len) begin
                  ph_d   = PH_MEAS;
                  tcnt_d = '0;
               end else if (unit_step) begin
                  tcnt_d = tcnt_q + 1'b1;
               end
            end
            PH_MEAS: begin
               if (win_done) begin
                  tcnt_d = '0;
                  ph_d   = dur_hit ? PH_IDLE : PH_WAIT;
               end
            end
            PH_WAIT: begin
               if (dur_hit) begin
                  ph_d = PH_IDLE;
               end else if (tcnt_q == wait_len) begin
                  ph_d   = PH_MEAS;
                  tcnt_d = '0;
               end else if (unit_step) begin
                  tcnt_d = tcnt_q + 1'b1;
               end
            end
            default: ph_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         tcnt_q <= '0;
         dcnt_q <= '0;
      end else begin
         ph_q   <= ph_d;
         tcnt_q <= tcnt_d;
         dcnt_q <= dcnt_d;
      end
   end

   assign phase = ph_q;

endmodule

// File: rtl/rssi_accum.sv
module rssi_accum #(
   parameter int unsigned SMP_W   = 16,
   parameter int unsigned LOG_MAX = 8,
   parameter int unsigned LW      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             meas_en,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] smp_pwr,
   input  logic [LW-1:0]    win_log2,
   output logic             win_done,
   output logic [SMP_W-1:0] rssi_avg,
   output logic             rssi_rdy
);

   localparam int unsigned CNT_W = LOG_MAX + 1;
   localparam int unsigned ACC_W = SMP_W + LOG_MAX;

   logic [LW-1:0] log_eff;
   assign log_eff = (win_log2 > LW'(LOG_MAX)) ? LW'(LOG_MAX) : win_log2;

   if (LOG_MAX == 0) begin : g_single
      // one-sample windows: the mean is the sample itself
      assign win_done = meas_en & smp_vld & ~clr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rssi_avg <= '0;
            rssi_rdy <= 1'b0;
         end else begin
            rssi_rdy <= win_done;
            if (win_done) rssi_avg <= smp_pwr;
         end
      end
   end else begin : g_acc
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] sum;
      logic [CNT_W-1:0] scnt_q;
      logic [CNT_W-1:0] last;

      assign last     = (CNT_W'(1) << log_eff) - CNT_W'(1);
      assign sum      = acc_q + ACC_W'(smp_pwr);
      assign win_done = meas_en & smp_vld & ~clr & (scnt_q == last);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q    <= '0;
            scnt_q   <= '0;
            rssi_avg <= '0;
            rssi_rdy <= 1'b0;
         end else begin
            rssi_rdy <= 1'b0;
            if (clr || !meas_en) begin
               acc_q  <= '0;
               scnt_q <= '0;
            end else if (smp_vld) begin
               if (scnt_q == last) begin
                  acc_q    <= '0;
                  scnt_q   <= '0;
                  rssi_avg <= SMP_W'(sum >> log_eff);
                  rssi_rdy <= 1'b1;
               end else begin
                  acc_q  <= sum;
                  scnt_q <= scnt_q + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/rssi_sched.sv
module rssi_sched
   import rssi_sched_pkg::*;
#(
   parameter  int unsigned SMP_W   = 16,
   parameter  int unsigned TIM_W   = 8,
   parameter  int unsigned DUR_W   = 16,
   parameter  int unsigned DIV_W   = 8,
   parameter  int unsigned LOG_MAX = 8,
   localparam int unsigned LW      = (LOG_MAX < 1) ? 1 : $clog2(LOG_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] smp_pwr,
   input  logic             smp_vld,
   input  logic             gain_locked,
   input  logic             agc_en_pin,
   input  logic             rx_enter,
   input  logic             gain_chg,
   input  logic             cfg_wr,
   input  logic [2:0]       trig_mode,
   input  logic             unit_is_smp,
   input  logic [DIV_W-1:0] clk_per_us,
   input  logic [TIM_W-1:0] delay_len,
   input  logic [TIM_W-1:0] wait_len,
   input  logic [DUR_W-1:0] dur_len,
   input  logic [LW-1:0]    win_log2,
   output logic [SMP_W-1:0] rssi_avg,
   output logic             rssi_rdy
);

   if (SMP_W < 1)    begin : g_bad_smp $error("SMP_W must be at least 1"); end
   if (TIM_W < 1)    begin : g_bad_tim $error("TIM_W must be at least 1"); end
   if (DUR_W < 1)    begin : g_bad_dur $error("DUR_W must be at least 1"); end
   if (DIV_W < 1)    begin : g_bad_div $error("DIV_W must be at least 1"); end
   if (LOG_MAX > 16) begin : g_bad_log $error("LOG_MAX must not exceed 16"); end

   logic        restart;
   logic        unit_step;
   logic        win_done;
   rssi_phase_e phase;

   rssi_trig_sel u_trig (
      .clk         (clk),
      .rst_n       (rst_n),
      .gain_locked (gain_locked),
      .agc_en_pin  (agc_en_pin),
      .rx_enter    (rx_enter),
      .gain_chg    (gain_chg),
      .cfg_wr      (cfg_wr),
      .trig_mode   (trig_mode),
      .restart     (restart)
   );

   rssi_unit_tick #(.DIV_W(DIV_W)) u_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .clk_per_us  (clk_per_us),
      .unit_is_smp (unit_is_smp),
      .smp_vld     (smp_vld),
      .unit_step   (unit_step)
   );

   rssi_phase_fsm #(.TIM_W(TIM_W), .DUR_W(DUR_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .unit_step (unit_step),
      .win_done  (win_done),
      .delay_len (delay_len),
      .wait_len  (wait_len),
      .dur_len   (dur_len),
      .phase     (phase)
   );

   rssi_accum #(.SMP_W(SMP_W), .LOG_MAX(LOG_MAX), .LW(LW)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (restart),
      .meas_en  (phase == PH_MEAS),
      .smp_vld  (smp_vld),
      .smp_pwr  (smp_pwr),
      .win_log2 (win_log2),
      .win_done (win_done),
      .rssi_avg (rssi_avg),
      .rssi_rdy (rssi_rdy)
   );

endmodule

// File: rtl/rssi_sched_chk.sv
module rssi_sched_chk
   import rssi_sched_pkg::*;
#(
   parameter int unsigned SMP_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gain_locked,
   input logic             agc_en_pin,
   input logic             rx_enter,
   input logic             gain_chg,
   input logic             cfg_wr,
   input logic             restart,
   input logic [1:0]       phase,
   input logic [SMP_W-1:0] rssi_avg,
   input logic             rssi_rdy
);

   // R1: a restart always follows some source activity
   assert_restart_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> $past(gain_locked | agc_en_pin | rx_enter | gain_chg | cfg_wr));

   // R9: a restart sends the sequencer to the delay phase
   assert_restart_to_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == PH_DELAY));

   // R4: no result leaves the delay phase
   assert_no_rdy_after_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DELAY) |=> !rssi_rdy);

   // R5: ready is a single-cycle pulse
   assert_single_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rssi_rdy |=> !rssi_rdy);

   // R5: the result only changes together with ready
   assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rssi_rdy |-> $stable(rssi_avg));

   // R10: idle produces no result
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |=> !rssi_rdy);

   // R7: only a restart leaves idle
   assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_IDLE) && !restart) |=> (phase == PH_IDLE));

endmodule

bind rssi_sched rssi_sched_chk #(.SMP_W(SMP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gain_locked (gain_locked),
   .agc_en_pin  (agc_en_pin),
   .rx_enter    (rx_enter),
   .gain_chg    (gain_chg),
   .cfg_wr      (cfg_wr),
   .restart     (restart),
   .phase       (phase),
   .rssi_avg    (rssi_avg),
   .rssi_rdy    (rssi_rdy)
);

// File: tb/rssi_sched_test.sv
module rssi_sched_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] smp_pwr = '0;
   logic        smp_vld = 1'b0;
   logic        gain_locked = 1'b0;
   logic        agc_en_pin = 1'b0;
   logic        rx_enter = 1'b0;
   logic        gain_chg = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  trig_mode = 3'd0;
   logic        unit_is_smp = 1'b1;
   logic [7:0]  clk_per_us = 8'd4;
   logic [7:0]  delay_len = 8'd1;
   logic [7:0]  wait_len = 8'd0;
   logic [15:0] dur_len = 16'd0;
   logic [3:0]  win_log2 = 4'd2;
   logic [15:0] rssi_avg;
   logic        rssi_rdy;

   always #5 clk = ~clk;

   rssi_sched uut (
      .clk(clk), .rst_n(rst_n), .smp_pwr(smp_pwr), .smp_vld(smp_vld),
      .gain_locked(gain_locked), .agc_en_pin(agc_en_pin), .rx_enter(rx_enter),
      .gain_chg(gain_chg), .cfg_wr(cfg_wr), .trig_mode(trig_mode),
      .unit_is_smp(unit_is_smp), .clk_per_us(clk_per_us), .delay_len(delay_len),
      .wait_len(wait_len), .dur_len(dur_len), .win_log2(win_log2),
      .rssi_avg(rssi_avg), .rssi_rdy(rssi_rdy)
   );

   int checks = 0;
   int errs = 0;
   int rdy_cnt = 0;
   int cyc = 0;
   int res [0:255];
   bit done = 1'b0;

   // vector: [6:4] trigger mode, [3:1] event index, [0] restart expected
   // event index: 0 gain_locked rise, 1 agc_en_pin rise, 2 rx_enter, 3 gain_chg, 4 cfg_wr
   localparam logic [6:0] VT [16] = '{
      7'b000_000_1, 7'b000_011_0,
      7'b001_001_1, 7'b001_000_0,
      7'b010_010_1, 7'b010_100_0,
      7'b011_011_1, 7'b011_010_0,
      7'b100_100_1, 7'b100_011_0,
      7'b101_011_1, 7'b101_001_1, 7'b101_100_0,
      7'b110_010_1, 7'b110_011_0,
      7'b111_010_1
   };

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && rssi_rdy) begin
         if (rdy_cnt < 256) res[rdy_cnt] = int'(rssi_avg);
         rdy_cnt = rdy_cnt + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic smp(input int v);
      @(negedge clk);
      smp_vld = 1'b1;
      smp_pwr = 16'(v);
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic evt(input int e);
      @(negedge clk);
      case (e)
         0: gain_locked = 1'b1;
         1: agc_en_pin  = 1'b1;
         2: rx_enter    = 1'b1;
         3: gain_chg    = 1'b1;
         default: cfg_wr = 1'b1;
      endcase
      @(negedge clk);
      gain_locked = 1'b0; agc_en_pin = 1'b0; rx_enter = 1'b0;
      gain_chg = 1'b0; cfg_wr = 1'b0;
      idle(3);
   endtask

   task automatic cfg(input int d, input int l, input int w, input int dur);
      @(negedge clk);
      delay_len = 8'(d);
      win_log2  = 4'(l);
      wait_len  = 8'(w);
      dur_len   = 16'(dur);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      int c0;
      int lat;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R10: reset state and no result without a restart
      chk("R10 rdy after reset", int'(rssi_rdy), 0);
      chk("R10 avg after reset", int'(rssi_avg), 0);
      c0 = rdy_cnt;
      for (int k = 0; k < 8; k++) smp(40);
      idle(3);
      chk("R10 no result before restart", rdy_cnt - c0, 0);

      // trigger-mode table: delay 1, windows of 4, single window
      cfg(1, 2, 0, 0);
      for (int i = 0; i < 16; i++) begin
         string req;
         logic [2:0] m;
         logic [2:0] e;
         logic       ex;
         m  = VT[i][6:4];
         e  = VT[i][3:1];
         ex = VT[i][0];
         req = (m > 3'd5) ? "R2 mode fold" : (ex ? "R1 mode source" : "R3 unselected source");
         @(negedge clk);
         trig_mode = m;
         idle(2);
         evt(int'(e));
         c0 = rdy_cnt;
         for (int k = 0; k < 5; k++) smp((i + 1) * 3);
         idle(4);
         chk(req, rdy_cnt - c0, int'(ex));
         if (ex) chk(req, int'(rssi_avg), (i + 1) * 3);
      end

      // R5 R6 R7: delay 2, windows of 4, wait 3, duration 15 -> three windows
      @(negedge clk) trig_mode = 3'd4;
      cfg(2, 2, 3, 15);
      evt(4);
      c0 = rdy_cnt;
      for (int k = 1; k <= 24; k++) smp(k * 10);
      idle(6);
      chk("R7 windows within duration 15", rdy_cnt - c0, 3);
      chk("R5 first window mean", res[c0], 45);
      chk("R6 second window after wait", res[c0 + 1], 115);
      chk("R6 third window after wait", res[c0 + 2], 185);

      // R7: duration 14 expires inside the second wait
      cfg(2, 2, 3, 14);
      evt(4);
      c0 = rdy_cnt;
      for (int k = 1; k <= 24; k++) smp(k * 10);
      idle(6);
      chk("R7 windows within duration 14", rdy_cnt - c0, 2);
      chk("R7 last result", int'(rssi_avg), 115);

      // R5: mean rounds down
      cfg(0, 2, 0, 0);
      evt(4);
      c0 = rdy_cnt;
      smp(1); smp(2); smp(2); smp(2);
      idle(4);
      chk("R5 floor of mean", int'(rssi_avg), 1);
      chk("R5 one ready", rdy_cnt - c0, 1);

      // R5 R7: single-sample windows, duration 2
      cfg(0, 0, 0, 2);
      evt(4);
      c0 = rdy_cnt;
      smp(9); smp(13); smp(50);
      idle(4);
      chk("R7 single-sample window count", rdy_cnt - c0, 2);
      chk("R5 single-sample first", res[c0], 9);
      chk("R5 single-sample second", res[c0 + 1], 13);

      // R5: result holds while idle
      c0 = rdy_cnt;
      for (int k = 0; k < 6; k++) smp(999);
      idle(30);
      chk("R5 result held", int'(rssi_avg), 13);
      chk("R5 no extra ready", rdy_cnt - c0, 0);

      // R4: three delay samples are discarded
      cfg(3, 1, 0, 0);
      evt(4);
      c0 = rdy_cnt;
      smp(900); smp(900); smp(900); smp(6); smp(10);
      idle(4);
      chk("R4 delay samples excluded", int'(rssi_avg), 8);
      chk("R4 one ready", rdy_cnt - c0, 1);

      // R8: microsecond units, 4 clocks per tick, delay 5 us
      cfg(5, 2, 0, 0);
      @(negedge clk);
      unit_is_smp = 1'b0;
      smp_pwr = 16'd77;
      smp_vld = 1'b1;
      idle(2);
      c0 = rdy_cnt;
      @(negedge clk);
      cfg_wr = 1'b1;
      lat = cyc;
      @(negedge clk);
      cfg_wr = 1'b0;
      for (int k = 0; k < 80; k++) begin
         if (rdy_cnt == c0) @(negedge clk);
      end
      lat = cyc - lat;
      chk("R8 microsecond delay latency in 20..28", (lat >= 20 && lat <= 28) ? 1 : 0, 1);
      chk("R8 microsecond result", int'(rssi_avg), 77);
      @(negedge clk);
      smp_vld = 1'b0;
      unit_is_smp = 1'b1;
      idle(2);

      // R9: restart mid-window discards the partial sum
      cfg(1, 2, 0, 100);
      evt(4);
      c0 = rdy_cnt;
      smp(500); smp(1000); smp(1000);
      evt(4);
      smp(1); smp(4); smp(4); smp(4); smp(8);
      idle(4);
      chk("R9 one result after abort", rdy_cnt - c0, 1);
      chk("R9 result excludes aborted samples", int'(rssi_avg), 5);

      finish_run();
   end

endmodule